// File: doc/BRIEF.md
# HDLC Interframe Flag Sequencer

This block is the framing stage of a serial HDLC transmitter. A payload source upstream hands it bits that are already zero-stuffed and carry a valid flag and an end-of-frame marker. The block puts a flag byte (0x7E) on the serial line before each frame and after it. Between two frames it keeps a configurable minimum gap, measured in flags, and it fills the line with flags whenever no frame is waiting. One output bit is produced per cycle in which the bit-rate enable is high.

A 4-bit gap setting gives the number of extra flags required between frames. A sharing option, which takes effect only while the request-to-send mode input is high, lets one flag serve as both the closing flag of one frame and the opening flag of the next. In that mode a nonzero gap setting is reduced by one. The gap setting and the sharing option are captured when the last payload bit of a frame is accepted. Changing them while a frame or a gap is in progress therefore has no effect on that gap.

Top module: `hdlc_flag_seq`

## Requirements
- R1: While reset is held, and until the first enabled cycle after it, `tx_bit` is 1 and `src_ready` is 0. After reset exactly one flag is sent before the first frame's payload.
- R2: Every flag is 0x7E sent LSB first, so the line carries 0,1,1,1,1,1,1,0.
- R3: With sharing not in effect, the line carries exactly N+2 flags between the last payload bit of one frame and the first payload bit of the next, where N is `cfg_gap_cnt` (0..15). With N=0 that is a closing flag followed directly by an opening flag.
- R4: With sharing in effect and N=0, back-to-back frames are separated by exactly one flag.
- R5: With sharing in effect and N>0, back-to-back frames are separated by exactly N flags: one shared flag plus N-1 extra.
- R6: Sharing is in effect only when both `cfg_share_en` and `cfg_rts_mode` are 1. With `cfg_rts_mode`=0 the gap is N+2 even if `cfg_share_en`=1.
- R7: A frame only begins right after a complete flag. When no frame is pending after the minimum gap, whole flags keep being sent until one is.
- R8: `src_ready` is 1 only during the payload phase. A payload bit is accepted on a cycle with `bit_en`, `src_valid` and `src_ready` all high, and it appears on `tx_bit` after that edge. Accepting a bit with `src_last`=1 ends the payload phase.
- R9: The gap setting and the sharing option are sampled when the last payload bit of a frame is accepted. A change made during the gap that follows does not alter that gap.
- R10: `tx_bit` changes only on clock edges where `bit_en` is 1. Gating the enable stretches the line but leaves the bit sequence unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_en | input | 1 | Bit-rate enable; one line bit per enabled cycle |
| cfg_gap_cnt | input | 4 | Minimum extra flags between frames (N) |
| cfg_share_en | input | 1 | Request one shared flag between frames |
| cfg_rts_mode | input | 1 | Request-to-send mode; sharing needs this set |
| src_valid | input | 1 | Payload bit is available |
| src_bit | input | 1 | Stuffed payload bit |
| src_last | input | 1 | Marks the final payload bit of a frame |
| src_ready | output | 1 | Block is in the payload phase and accepts bits |
| tx_bit | output | 1 | Serial line bit, registered |

If the source has no bit ready during the payload phase, the line carries a 1 for that slot.

## Verification
An error in the flag bit position would break the 0x7E pattern on the line within eight enabled cycles. An off-by-one in the gap budget would add or drop a whole flag, which means eight bits of misalignment that surface at the first payload bit of the next frame. A wrong phase bit would either raise `src_ready` in the middle of a flag or keep the source stalled. That shows up as a payload bit out of place, or as payload that never drains, within one flag time. The bench compares every line bit against a stream it builds from the requirements. Any such error therefore appears as a mismatch at the first displaced bit.

// File: rtl/hdlc_flag_pkg.sv
package hdlc_flag_pkg;

    localparam int          FLAG_LEN = 8;
    localparam logic [7:0]  FLAG_PAT = 8'h7E;

    typedef enum logic {
        PH_FLAG = 1'b0,
        PH_DATA = 1'b1
    } seq_phase_e;

endpackage

// File: rtl/hdlc_gap_calc.sv
module hdlc_gap_calc #(
    parameter int CNT_W  = 4,
    parameter int OWED_W = CNT_W + 2
) (
    input  logic [CNT_W-1:0]  gap_cnt,
    input  logic              share_en,
    input  logic              rts_mode,
    output logic [OWED_W-1:0] flags_owed
);

    logic share_eff;

    always_comb begin
        share_eff = share_en & rts_mode;
        if (share_eff) begin
            if (gap_cnt == '0) flags_owed = OWED_W'(1);
            else               flags_owed = OWED_W'(gap_cnt);
        end else begin
            flags_owed = OWED_W'(gap_cnt) + OWED_W'(2);
        end
    end

endmodule

// File: rtl/hdlc_flag_pos.sv
module hdlc_flag_pos #(
    parameter int LEN = 8,
    parameter int W   = $clog2(LEN)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         adv,
    output logic [W-1:0] pos,
    output logic         at_end
);

    localparam logic [W-1:0] LAST_POS = W'(LEN - 1);

    logic [W-1:0] pos_d, pos_q;

    always_comb begin
        pos_d = pos_q;
        if (adv) begin
            if (pos_q == LAST_POS) pos_d = '0;
            else                   pos_d = pos_q + W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pos_q <= '0;
        else        pos_q <= pos_d;
    end

    assign pos    = pos_q;
    assign at_end = (pos_q == LAST_POS);

endmodule

// File: rtl/hdlc_flag_seq.sv
module hdlc_flag_seq
    import hdlc_flag_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_en,
    input  logic [CNT_W-1:0] cfg_gap_cnt,
    input  logic             cfg_share_en,
    input  logic             cfg_rts_mode,
    input  logic             src_valid,
    input  logic             src_bit,
    input  logic             src_last,
    output logic             src_ready,
    output logic             tx_bit
);

    localparam int OWED_W = CNT_W + 2;
    localparam int POS_W  = $clog2(FLAG_LEN);

    typedef struct packed {
        seq_phase_e        phase;
        logic [OWED_W-1:0] owed;
        logic              tx_bit;
    } seq_state_t;

    localparam seq_state_t RESET_STATE = '{
        phase:  PH_FLAG,
        owed:   OWED_W'(1),
        tx_bit: 1'b1
    };

    seq_state_t        st_d, st_q;
    logic [OWED_W-1:0] gap_need;
    logic [POS_W-1:0]  flag_pos;
    logic              flag_end;
    logic              flag_adv;

    hdlc_gap_calc #(
        .CNT_W  (CNT_W),
        .OWED_W (OWED_W)
    ) u_gap (
        .gap_cnt    (cfg_gap_cnt),
        .share_en   (cfg_share_en),
        .rts_mode   (cfg_rts_mode),
        .flags_owed (gap_need)
    );

    hdlc_flag_pos #(
        .LEN (FLAG_LEN),
        .W   (POS_W)
    ) u_pos (
        .clk    (clk),
        .rst_n  (rst_n),
        .adv    (flag_adv),
        .pos    (flag_pos),
        .at_end (flag_end)
    );

    always_comb begin
        st_d     = st_q;
        flag_adv = 1'b0;
        if (bit_en) begin
            unique case (st_q.phase)
                PH_FLAG: begin
                    flag_adv    = 1'b1;
                    st_d.tx_bit = FLAG_PAT[flag_pos];
                    if (flag_end) begin
                        if (st_q.owed != '0) st_d.owed = st_q.owed - OWED_W'(1);
                        if ((st_q.owed <= OWED_W'(1)) && src_valid) begin
                            st_d.phase = PH_DATA;
                        end
                    end
                end
                PH_DATA: begin
                    if (src_valid) begin
                        st_d.tx_bit = src_bit;
                        if (src_last) begin
                            st_d.phase = PH_FLAG;
                            st_d.owed  = gap_need;
                        end
                    end else begin
                        st_d.tx_bit = 1'b1;
                    end
                end
                default: st_d = RESET_STATE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= RESET_STATE;
        else        st_q <= st_d;
    end

    assign src_ready = (st_q.phase == PH_DATA);
    assign tx_bit    = st_q.tx_bit;

endmodule

// File: rtl/hdlc_flag_seq_chk.sv
module hdlc_flag_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic bit_en,
    input logic src_valid,
    input logic src_bit,
    input logic src_last,
    input logic src_ready,
    input logic tx_bit
);

    AST_HOLD_WITHOUT_EN: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> $stable(tx_bit)); // R10

    AST_PAYLOAD_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && src_ready && src_valid) |=> (tx_bit == $past(src_bit))); // R8

    AST_LAST_ENDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && src_ready && src_valid && src_last) |=> !src_ready); // R8

    AST_START_ON_EN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(src_ready) |-> $past(bit_en)); // R7

    AST_START_AFTER_FLAG_END: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(src_ready) |-> (tx_bit == 1'b0)); // R2

endmodule

bind hdlc_flag_seq hdlc_flag_seq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_en    (bit_en),
    .src_valid (src_valid),
    .src_bit   (src_bit),
    .src_last  (src_last),
    .src_ready (src_ready),
    .tx_bit    (tx_bit)
);

// File: tb/hdlc_flag_seq_bench.sv
module hdlc_flag_seq_bench;

    localparam logic [7:0] FLAG  = 8'h7E;
    localparam int         LIMIT = 20000;

    typedef struct { logic b; logic last; } src_item_t;
    typedef struct { logic b; string tag; } exp_item_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_en = 1'b0;
    logic [3:0] cfg_gap_cnt = '0;
    logic       cfg_share_en = 1'b0;
    logic       cfg_rts_mode = 1'b0;
    logic       src_valid = 1'b0;
    logic       src_bit = 1'b0;
    logic       src_last = 1'b0;
    logic       src_ready;
    logic       tx_bit;

    src_item_t src_q[$];
    exp_item_t exp_q[$];

    int    tests = 0;
    int    fails = 0;
    int    xfer_cnt = 0;
    logic  mon_on = 1'b0;
    logic  en_mode = 1'b0;
    logic  en_seen = 1'b0;
    logic  xfer_seen = 1'b0;
    logic [15:0] lfsr = 16'hACE1;

    always #4 clk = ~clk;

    hdlc_flag_seq u_hdlc_flag_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .bit_en       (bit_en),
        .cfg_gap_cnt  (cfg_gap_cnt),
        .cfg_share_en (cfg_share_en),
        .cfg_rts_mode (cfg_rts_mode),
        .src_valid    (src_valid),
        .src_bit      (src_bit),
        .src_last     (src_last),
        .src_ready    (src_ready),
        .tx_bit       (tx_bit)
    );

    always @(posedge clk) begin
        en_seen   <= rst_n & bit_en;
        xfer_seen <= rst_n & bit_en & src_valid & src_ready;
    end

    // monitor, source driver and enable generator
    always @(negedge clk) begin
        if (mon_on && en_seen && exp_q.size() > 0) begin
            exp_item_t e;
            e = exp_q.pop_front();
            tests++;
            if (tx_bit !== e.b) begin
                fails++;
                $display("FAIL %s: tx_bit=%0b expected %0b (%0d bits left)",
                         e.tag, tx_bit, e.b, exp_q.size());
            end
        end
        if (xfer_seen && src_q.size() > 0) begin
            void'(src_q.pop_front());
            xfer_cnt++;
        end
        if (src_q.size() > 0) begin
            src_valid = 1'b1;
            src_bit   = src_q[0].b;
            src_last  = src_q[0].last;
        end else begin
            src_valid = 1'b0;
            src_bit   = 1'b0;
            src_last  = 1'b0;
        end
        bit_en = en_mode ? lfsr[0] : 1'b1;
        lfsr   = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    end

    task automatic check(input string tag, input logic got, input logic want);
        tests++;
        if (got !== want) begin
            fails++;
            $display("FAIL %s: got %0b expected %0b", tag, got, want);
        end
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    function automatic int gap_of(input int n, input bit sh, input bit rts);
        if (sh && rts) return (n == 0) ? 1 : n;
        return n + 2;
    endfunction

    function automatic string tag_of(input int n, input bit sh, input bit rts);
        if (sh && !rts) return "R6";
        if (sh)         return (n == 0) ? "R4" : "R5";
        return "R3";
    endfunction

    function automatic int len_of(input int f);
        case (f % 4)
            0:       return 13;
            1:       return 1;
            2:       return 24;
            default: return 7;
        endcase
    endfunction

    function automatic logic pay_bit(input int f, input int j);
        logic [7:0] pats [5];
        pats = '{8'hA5, 8'h3C, 8'h12, 8'hC3, 8'h5A};
        return pats[(f + j / 8) % 5][j % 8];
    endfunction

    task automatic push_flags(input int n, input string tag);
        for (int k = 0; k < n; k++)
            for (int j = 0; j < 8; j++) exp_q.push_back('{FLAG[j], tag});
    endtask

    // driver: loads source bits and the expected line stream, then waits for it to drain
    task automatic run(input int n, input bit sh, input bit rts, input int nfr,
                       input bit rnd, input bit mid, input int n2, input bit sh2, input bit rts2);
        int cyc;
        mon_on = 1'b0;
        rst_n  = 1'b0;
        cfg_gap_cnt  = 4'(n);
        cfg_share_en = sh;
        cfg_rts_mode = rts;
        src_q.delete();
        exp_q.delete();
        xfer_cnt = 0;
        en_mode  = rnd;
        repeat (3) @(negedge clk);
        check("R1 reset tx_bit", tx_bit, 1'b1);
        check("R1 reset src_ready", src_ready, 1'b0);

        push_flags(1, "R1");
        for (int f = 0; f < nfr; f++) begin
            int    g;
            string t;
            for (int j = 0; j < len_of(f); j++) begin
                src_q.push_back('{pay_bit(f, j), (j == len_of(f) - 1)});
                exp_q.push_back('{pay_bit(f, j), rnd ? "R10" : "R8"});
            end
            if (mid && f > 0) g = gap_of(n2, sh2, rts2);
            else              g = gap_of(n, sh, rts);
            t = mid ? "R9" : (rnd ? "R10" : tag_of(n, sh, rts));
            if (f == 0) begin
                exp_q.push_back('{1'b0, t});
                void'(exp_q.pop_back());
            end
            push_flags(g, t);
            if (f == nfr - 1) push_flags(4, "R7");
        end

        mon_on = 1'b1;
        rst_n  = 1'b1;
        cyc = 0;
        if (mid) begin
            while (xfer_cnt < len_of(0) && cyc < LIMIT) begin
                @(negedge clk);
                cyc++;
            end
            repeat (20) @(negedge clk);
            cfg_gap_cnt  = 4'(n2);
            cfg_share_en = sh2;
            cfg_rts_mode = rts2;
        end
        while (exp_q.size() > 0 && cyc < LIMIT) begin
            @(negedge clk);
            cyc++;
        end
        if (exp_q.size() > 0) begin
            fails++;
            $display("FAIL watchdog: %0d bits never seen, expected 0", exp_q.size());
            finish_run();
        end
        check("R8 source drained", src_q.size() == 0, 1'b1);
        check("R8 idle not ready", src_ready, 1'b0);
    endtask

    initial begin
        // sharing off, counts 0, 1, 15
        run(0,  1'b0, 1'b1, 3, 1'b0, 1'b0, 0, 1'b0, 1'b0);
        run(1,  1'b0, 1'b1, 3, 1'b0, 1'b0, 0, 1'b0, 1'b0);
        run(15, 1'b0, 1'b1, 3, 1'b0, 1'b0, 0, 1'b0, 1'b0);
        // sharing on
        run(0,  1'b1, 1'b1, 3, 1'b0, 1'b0, 0, 1'b0, 1'b0);
        run(1,  1'b1, 1'b1, 3, 1'b0, 1'b0, 0, 1'b0, 1'b0);
        run(15, 1'b1, 1'b1, 3, 1'b0, 1'b0, 0, 1'b0, 1'b0);
        // sharing requested without request-to-send mode
        run(0,  1'b1, 1'b0, 3, 1'b0, 1'b0, 0, 1'b0, 1'b0);
        run(4,  1'b1, 1'b0, 2, 1'b0, 1'b0, 0, 1'b0, 1'b0);
        // configuration changed during a gap
        run(15, 1'b0, 1'b1, 3, 1'b0, 1'b1, 0, 1'b1, 1'b1);
        // gated bit enable
        run(1,  1'b1, 1'b1, 4, 1'b1, 1'b0, 0, 1'b0, 1'b0);
        run(2,  1'b0, 1'b1, 3, 1'b1, 1'b0, 0, 1'b0, 1'b0);
        finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not end, expected completion");
        finish_run();
    end

endmodule